// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the transmit and receive error counters of a CAN controller and turns them into the node's fault-confinement standing: a warning condition, an error-passive condition and bus-off. The protocol engine feeds it one-cycle strobes for transmit errors, receive errors and successful frames. Software reaches the counters and the warning limit through a small write port, and that port only works while the controller sits in reset mode. The block drives two status bits (error and bus), an error-passive flag, two enable-gated interrupt pulses, and a request line that asks the mode register owner to force reset mode.

When the transmit counter would reach 256, the node goes bus-off. The transmit counter is loaded with 127, the receive counter is cleared and reset mode is requested. Recovery does not begin until software has seen reset mode and then cleared it. From then on, every strobe for eleven consecutive recessive bits lowers the transmit counter by one. The warning interrupt fires once when the counter falls under the limit while the bus bit is still set. The 128th strobe ends recovery and returns the node to error active.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters read 0, the warning limit is 96, and every status bit, interrupt and the reset-mode request are low.
- R2: Outside reset mode a transmit-error strobe adds 8 to the transmit counter and a receive-error strobe adds 1 to the receive counter. A transmit-success strobe takes 1 from the transmit counter and a receive-success strobe takes 1 from the receive counter. Both counters stop at 0 and the receive counter stops at 255.
- R3: Outside reset mode, `err_status` rises on the clock after either counter becomes greater than or equal to the warning limit. It falls on the clock after both counters are below the limit.
- R4: `err_passive` is set when either counter is at least 128. It clears once both counters are below 128, and it is never set while bus-off. Every change of `err_passive` gives one `passive_irq` pulse.
- R5: Every change of `bus_status` or `err_status` gives one `warn_irq` pulse, and `warn_irq` fires only on such a change.
- R6: A transmit-error strobe that would take the transmit counter to 256 or more enters bus-off at that clock edge. `bus_status` goes to 1, the transmit counter to 127, the receive counter to 0 and `err_passive` to 0. `force_reset` then stays high until `reset_mode` is seen high.
- R7: Recessive-sequence strobes have no effect while bus-off until `reset_mode` has been seen high and then low.
- R8: During recovery each recessive-sequence strobe takes 1 from the transmit counter. When the counter drops under the limit, `warn_irq` fires with `bus_status` 1 and `err_status` 0. The strobe that arrives with the counter at 0 (the 128th) clears `bus_status`, and both counters then read 0.
- R9: `wr_data` is written only while `reset_mode` is high. `wr_sel` selects the target: 0 is the transmit counter, 1 the receive counter, 2 the warning limit, and 3 writes nothing.
- R10: While `reset_mode` is high, `err_status` and `err_passive` hold their values and no interrupt follows from counter values. Written values take effect on the clock after `reset_mode` falls.
- R11: The receive counter still counts in reset mode. While `listen_only` is high, receive strobes leave it unchanged.
- R12: Transmit strobes are ignored in reset mode and while bus-off.
- R13: Interrupts are single-cycle pulses. `irq_en` bit 0 enables `warn_irq` and bit 1 enables `passive_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_mode | input | 1 | Current reset-mode bit of the controller |
| listen_only | input | 1 | Listen-only mode; freezes the receive counter |
| tx_err | input | 1 | Transmit error strobe |
| tx_ok | input | 1 | Successful transmission strobe |
| rx_err | input | 1 | Receive error strobe |
| rx_ok | input | 1 | Successful reception strobe |
| recessive11 | input | 1 | Eleven consecutive recessive bits seen |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 transmit counter, 1 receive counter, 2 warning limit |
| wr_data | input | 8 | Write data |
| irq_en | input | 2 | Bit 0 enables warn_irq, bit 1 enables passive_irq |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| err_status | output | 1 | A counter is at or above the warning limit |
| bus_status | output | 1 | Bus-off or recovering |
| err_passive | output | 1 | Node is error passive |
| warn_irq | output | 1 | Pulse on a change of err_status or bus_status |
| passive_irq | output | 1 | Pulse on a change of err_passive |
| force_reset | output | 1 | Request to force reset mode after bus-off entry |

## Verification
A wrong counter value appears on `tec` or `rec` at the next clock edge. A wrong threshold decision appears one edge later on the status bits and as a missing or extra interrupt pulse. A bus-off state machine that is stuck or that skips a step shows up as a `force_reset` that never drops, as recovery strobes that change nothing, or as a `bus_status` that clears early or late against the 128-strobe count. Because the status bits are frozen in reset mode, a wrongly evaluated status can stay hidden until the clock after reset mode is left. The bench therefore checks every deferred case right after that edge.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int FC_CNT_W = 8;

  typedef enum logic [1:0] {
    FC_ACTIVE    = 2'd0,
    FC_OFF_ENTRY = 2'd1,
    FC_OFF_HELD  = 2'd2,
    FC_RECOVER   = 2'd3
  } fc_state_e;

  localparam logic [1:0] SEL_TEC = 2'd0;
  localparam logic [1:0] SEL_REC = 2'd1;
  localparam logic [1:0] SEL_EWL = 2'd2;

  // Sum one bit wider than the counter so that overflow is visible.
  function automatic logic [FC_CNT_W:0] fc_wide_add(input logic [FC_CNT_W-1:0] v,
                                                    input int unsigned step);
    return {1'b0, v} + (FC_CNT_W+1)'(step);
  endfunction

  function automatic logic [FC_CNT_W-1:0] fc_sat_add(input logic [FC_CNT_W-1:0] v,
                                                     input int unsigned step);
    logic [FC_CNT_W:0] s;
    s = fc_wide_add(v, step);
    return s[FC_CNT_W] ? {FC_CNT_W{1'b1}} : s[FC_CNT_W-1:0];
  endfunction

  function automatic logic [FC_CNT_W-1:0] fc_sat_dec(input logic [FC_CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters
  import can_fc_pkg::*;
#(
  parameter int unsigned TX_STEP  = 8,
  parameter int unsigned RX_STEP  = 1,
  parameter int unsigned EWL_INIT = 96
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fc_state_e           state,
  input  logic                reset_mode,
  input  logic                listen_only,
  input  logic                tx_err,
  input  logic                tx_ok,
  input  logic                rx_err,
  input  logic                rx_ok,
  input  logic                recessive11,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [FC_CNT_W-1:0] wr_data,
  output logic [FC_CNT_W-1:0] tec,
  output logic [FC_CNT_W-1:0] rec,
  output logic [FC_CNT_W-1:0] ewl,
  output logic                enter_busoff,
  output logic                recover_step,
  output logic                recover_done
);
  localparam logic [FC_CNT_W-1:0] BUSOFF_TEC = {1'b0, {(FC_CNT_W-1){1'b1}}};

  logic [FC_CNT_W-1:0] tec_q, rec_q, ewl_q, tec_n, rec_n;
  logic [FC_CNT_W:0]   tx_sum;
  logic                sw_wr;

  assign sw_wr        = reset_mode && wr_en;
  assign tx_sum       = fc_wide_add(tec_q, TX_STEP);
  assign enter_busoff = (state == FC_ACTIVE) && !reset_mode && tx_err && tx_sum[FC_CNT_W];
  assign recover_step = (state == FC_RECOVER) && !reset_mode && recessive11;
  assign recover_done = recover_step && (tec_q == '0);

  always_comb begin
    tec_n = tec_q;
    if (enter_busoff)                          tec_n = BUSOFF_TEC;
    else if (recover_step)                     tec_n = fc_sat_dec(tec_q);
    else if (reset_mode) begin
      if (sw_wr && wr_sel == SEL_TEC)          tec_n = wr_data;
    end else if (state == FC_ACTIVE) begin
      if (tx_err)                              tec_n = tx_sum[FC_CNT_W-1:0];
      else if (tx_ok)                          tec_n = fc_sat_dec(tec_q);
    end
  end

  always_comb begin
    rec_n = rec_q;
    if (enter_busoff || recover_done)          rec_n = '0;
    else if (sw_wr && wr_sel == SEL_REC)       rec_n = wr_data;
    else if (state == FC_ACTIVE && !listen_only) begin
      if (rx_err)                              rec_n = fc_sat_add(rec_q, RX_STEP);
      else if (rx_ok)                          rec_n = fc_sat_dec(rec_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
      ewl_q <= FC_CNT_W'(EWL_INIT);
    end else begin
      tec_q <= tec_n;
      rec_q <= rec_n;
      if (sw_wr && wr_sel == SEL_EWL) ewl_q <= wr_data;
    end
  end

  assign tec = tec_q;
  assign rec = rec_q;
  assign ewl = ewl_q;
endmodule

// File: rtl/fc_busoff_fsm.sv
module fc_busoff_fsm
  import can_fc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reset_mode,
  input  logic      enter_busoff,
  input  logic      recover_done,
  output fc_state_e state,
  output fc_state_e state_nxt,
  output logic      force_reset
);
  fc_state_e state_q;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      FC_ACTIVE:    if (enter_busoff) state_nxt = FC_OFF_ENTRY;
      FC_OFF_ENTRY: if (reset_mode)   state_nxt = FC_OFF_HELD;
      FC_OFF_HELD:  if (!reset_mode)  state_nxt = FC_RECOVER;
      FC_RECOVER:   if (recover_done) state_nxt = FC_ACTIVE;
      default:                        state_nxt = FC_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FC_ACTIVE;
    else        state_q <= state_nxt;
  end

  assign state       = state_q;
  assign force_reset = (state_q == FC_OFF_ENTRY);
endmodule

// File: rtl/fc_status_irq.sv
module fc_status_irq
  import can_fc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reset_mode,
  input  fc_state_e           state_nxt,
  input  logic [FC_CNT_W-1:0] tec,
  input  logic [FC_CNT_W-1:0] rec,
  input  logic [FC_CNT_W-1:0] ewl,
  input  logic [1:0]          irq_en,
  output logic                err_status,
  output logic                bus_status,
  output logic                err_passive,
  output logic                warn_irq,
  output logic                passive_irq
);
  localparam logic [FC_CNT_W-1:0] PASS_LVL = {1'b1, {(FC_CNT_W-1){1'b0}}};

  logic bus_q, err_q, pas_q, warn_q, pirq_q;
  logic bus_nxt, err_eval, pas_eval, err_nxt, pas_nxt;

  assign bus_nxt  = (state_nxt != FC_ACTIVE);
  assign err_eval = (tec >= ewl) || (!bus_nxt && rec >= ewl);
  assign pas_eval = !bus_nxt && ((tec >= PASS_LVL) || (rec >= PASS_LVL));
  assign err_nxt  = reset_mode ? err_q : err_eval;
  assign pas_nxt  = reset_mode ? pas_q : pas_eval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= 1'b0;
      err_q  <= 1'b0;
      pas_q  <= 1'b0;
      warn_q <= 1'b0;
      pirq_q <= 1'b0;
    end else begin
      bus_q  <= bus_nxt;
      err_q  <= err_nxt;
      pas_q  <= pas_nxt;
      warn_q <= irq_en[0] && ((bus_nxt != bus_q) || (err_nxt != err_q));
      pirq_q <= irq_en[1] && (pas_nxt != pas_q);
    end
  end

  assign bus_status  = bus_q;
  assign err_status  = err_q;
  assign err_passive = pas_q;
  assign warn_irq    = warn_q;
  assign passive_irq = pirq_q;
endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
  import can_fc_pkg::*;
#(
  parameter int unsigned TX_ERR_STEP = 8,
  parameter int unsigned RX_ERR_STEP = 1,
  parameter int unsigned EWL_RESET   = 96
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reset_mode,
  input  logic                listen_only,
  input  logic                tx_err,
  input  logic                tx_ok,
  input  logic                rx_err,
  input  logic                rx_ok,
  input  logic                recessive11,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [FC_CNT_W-1:0] wr_data,
  input  logic [1:0]          irq_en,
  output logic [FC_CNT_W-1:0] tec,
  output logic [FC_CNT_W-1:0] rec,
  output logic                err_status,
  output logic                bus_status,
  output logic                err_passive,
  output logic                warn_irq,
  output logic                passive_irq,
  output logic                force_reset
);
  fc_state_e           state, state_nxt;
  logic [FC_CNT_W-1:0] ewl;
  logic                enter_busoff, recover_step, recover_done;

  fc_err_counters #(
    .TX_STEP (TX_ERR_STEP),
    .RX_STEP (RX_ERR_STEP),
    .EWL_INIT(EWL_RESET)
  ) u_cnt (
    .clk, .rst_n, .state, .reset_mode, .listen_only,
    .tx_err, .tx_ok, .rx_err, .rx_ok, .recessive11,
    .wr_en, .wr_sel, .wr_data,
    .tec, .rec, .ewl, .enter_busoff, .recover_step, .recover_done
  );

  fc_busoff_fsm u_fsm (
    .clk, .rst_n, .reset_mode, .enter_busoff, .recover_done,
    .state, .state_nxt, .force_reset
  );

  fc_status_irq u_stat (
    .clk, .rst_n, .reset_mode, .state_nxt, .tec, .rec, .ewl, .irq_en,
    .err_status, .bus_status, .err_passive, .warn_irq, .passive_irq
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker
  import can_fc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reset_mode,
  input logic                listen_only,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic [1:0]          irq_en,
  input logic [FC_CNT_W-1:0] tec,
  input logic [FC_CNT_W-1:0] rec,
  input logic                err_status,
  input logic                bus_status,
  input logic                err_passive,
  input logic                warn_irq,
  input logic                passive_irq,
  input logic                force_reset,
  input logic                enter_busoff,
  input logic                recover_done
);
  assert_busoff_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enter_busoff |=> (bus_status && force_reset && !err_passive &&
                      tec == FC_CNT_W'(127) && rec == '0));

  assert_force_only_busoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_reset |-> bus_status);

  assert_recovery_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recover_done |=> (!bus_status && tec == '0 && rec == '0));

  assert_status_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> ($stable(err_status) && $stable(err_passive)));

  assert_listen_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (listen_only && !(reset_mode && wr_en && wr_sel == SEL_REC) &&
     !enter_busoff && !recover_done) |=> $stable(rec));

  assert_tx_ignored_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_mode && !bus_status && !(wr_en && wr_sel == SEL_TEC)) |=> $stable(tec));

  assert_warn_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> ($past(irq_en[0]) &&
                  (bus_status != $past(bus_status) || err_status != $past(err_status))));

  assert_passive_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    passive_irq |-> ($past(irq_en[1]) && err_passive != $past(err_passive)));

  assert_passive_not_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_passive |-> !bus_status);
endmodule

bind can_fault_tracker fc_checker u_fc_checker (
  .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .listen_only(listen_only),
  .wr_en(wr_en), .wr_sel(wr_sel), .irq_en(irq_en), .tec(tec), .rec(rec),
  .err_status(err_status), .bus_status(bus_status), .err_passive(err_passive),
  .warn_irq(warn_irq), .passive_irq(passive_irq), .force_reset(force_reset),
  .enter_busoff(enter_busoff), .recover_done(recover_done)
);

// File: tb/tb_can_fault_tracker.sv
module tb_can_fault_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_mode = 1'b0, listen_only = 1'b0;
  logic       tx_err = 1'b0, tx_ok = 1'b0, rx_err = 1'b0, rx_ok = 1'b0, recessive11 = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] irq_en = 2'b11;
  logic [7:0] tec, rec;
  logic       err_status, bus_status, err_passive, warn_irq, passive_irq, force_reset;

  int total = 0, bad = 0, wtot = 0, ptot = 0;
  int w0, p0;

  always #5 clk = ~clk;

  can_fault_tracker dut (.*);

  // Operation codes for the stimulus table.
  localparam int OP_TXERR = 0, OP_TXOK = 1, OP_RXERR = 2, OP_RXOK = 3, OP_REC11 = 4;

  typedef struct packed {
    logic [2:0] op;  logic [7:0] n;
    logic [7:0] tec; logic [7:0] rec;
    logic err; logic pas; logic [1:0] w; logic [1:0] p;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t ROWS [NROWS] = '{
    '{3'd2, 8'd95,  8'd0,   8'd95,  1'b0, 1'b0, 2'd0, 2'd0},
    '{3'd2, 8'd1,   8'd0,   8'd96,  1'b1, 1'b0, 2'd1, 2'd0},
    '{3'd2, 8'd31,  8'd0,   8'd127, 1'b1, 1'b0, 2'd0, 2'd0},
    '{3'd2, 8'd1,   8'd0,   8'd128, 1'b1, 1'b1, 2'd0, 2'd1},
    '{3'd3, 8'd1,   8'd0,   8'd127, 1'b1, 1'b0, 2'd0, 2'd1},
    '{3'd3, 8'd31,  8'd0,   8'd96,  1'b1, 1'b0, 2'd0, 2'd0},
    '{3'd3, 8'd1,   8'd0,   8'd95,  1'b0, 1'b0, 2'd1, 2'd0},
    '{3'd0, 8'd11,  8'd88,  8'd95,  1'b0, 1'b0, 2'd0, 2'd0},
    '{3'd0, 8'd1,   8'd96,  8'd95,  1'b1, 1'b0, 2'd1, 2'd0},
    '{3'd1, 8'd96,  8'd0,   8'd95,  1'b0, 1'b0, 2'd1, 2'd0},
    '{3'd3, 8'd100, 8'd0,   8'd0,   1'b0, 1'b0, 2'd0, 2'd0},
    '{3'd1, 8'd3,   8'd0,   8'd0,   1'b0, 1'b0, 2'd0, 2'd0},
    '{3'd0, 8'd16,  8'd128, 8'd0,   1'b1, 1'b1, 2'd1, 2'd1},
    '{3'd1, 8'd1,   8'd127, 8'd0,   1'b1, 1'b0, 2'd0, 2'd1},
    '{3'd1, 8'd127, 8'd0,   8'd0,   1'b0, 1'b0, 2'd1, 2'd0}
  };

  always @(negedge clk) if (rst_n) begin
    if (warn_irq)    wtot++;
    if (passive_irq) ptot++;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input int op, input logic v);
    case (op)
      OP_TXERR: tx_err      = v;
      OP_TXOK:  tx_ok       = v;
      OP_RXERR: rx_err      = v;
      OP_RXOK:  rx_ok       = v;
      default:  recessive11 = v;
    endcase
  endtask

  task automatic pulse_op(input int op, input int n);
    @(negedge clk); drive(op, 1'b1);
    repeat (n) @(negedge clk);
    drive(op, 1'b0);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
    #1;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk); reset_mode = v;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic mark;
    w0 = wtot; p0 = ptot;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1", "tec", tec, 0);
    chk("R1", "rec", rec, 0);
    chk("R1", "status", {err_status, bus_status, err_passive}, 0);
    chk("R1", "irq/force", {warn_irq, passive_irq, force_reset}, 0);

    // R2 R3 R4 R5 R13: table of counter steps and thresholds
    for (int r = 0; r < NROWS; r++) begin
      mark();
      pulse_op(int'(ROWS[r].op), int'(ROWS[r].n));
      chk("R2", $sformatf("row%0d tec", r), tec, ROWS[r].tec);
      chk("R2", $sformatf("row%0d rec", r), rec, ROWS[r].rec);
      chk("R3", $sformatf("row%0d err_status", r), err_status, ROWS[r].err);
      chk("R4", $sformatf("row%0d err_passive", r), err_passive, ROWS[r].pas);
      chk("R5", $sformatf("row%0d warn pulses", r), wtot - w0, ROWS[r].w);
      chk("R13", $sformatf("row%0d passive pulses", r), ptot - p0, ROWS[r].p);
    end

    // R9: write outside reset mode is ignored
    write_reg(2'd1, 8'd50);
    chk("R9", "rec after write outside reset", rec, 0);

    // R11 R2: receive counting in reset mode, saturation at 255
    set_mode(1'b1);
    write_reg(2'd1, 8'd254);
    chk("R9", "rec after write", rec, 254);
    mark();
    pulse_op(OP_RXERR, 3);
    chk("R11", "rec counts in reset mode", rec, 255);
    chk("R10", "err_status frozen", err_status, 0);
    chk("R10", "no irq in reset mode", (wtot - w0) + (ptot - p0), 0);

    // R11: listen-only freezes the receive counter
    listen_only = 1'b1;
    pulse_op(OP_RXOK, 2);
    pulse_op(OP_RXERR, 2);
    chk("R11", "rec frozen by listen_only", rec, 255);
    listen_only = 1'b0;

    // R12: transmit strobes ignored in reset mode
    pulse_op(OP_TXERR, 2);
    chk("R12", "tec in reset mode", tec, 0);

    // R10: written values take effect after leaving reset mode
    write_reg(2'd1, 8'd0);
    write_reg(2'd0, 8'd248);
    chk("R10", "err_status before exit", err_status, 0);
    mark();
    set_mode(1'b0);
    chk("R10", "err_status after exit", err_status, 1);
    chk("R10", "err_passive after exit", err_passive, 1);
    chk("R10", "warn pulse after exit", wtot - w0, 1);
    chk("R10", "passive pulse after exit", ptot - p0, 1);

    // R6: bus-off entry
    mark();
    pulse_op(OP_TXERR, 1);
    chk("R6", "bus_status", bus_status, 1);
    chk("R6", "tec loaded", tec, 127);
    chk("R6", "rec cleared", rec, 0);
    chk("R6", "err_passive", err_passive, 0);
    chk("R6", "force_reset", force_reset, 1);
    chk("R6", "warn pulse", wtot - w0, 1);
    chk("R6", "passive pulse", ptot - p0, 1);

    // R7: recovery waits for software
    pulse_op(OP_REC11, 5);
    chk("R7", "tec before reset seen", tec, 127);
    set_mode(1'b1);
    chk("R6", "force_reset released", force_reset, 0);
    pulse_op(OP_REC11, 5);
    chk("R7", "tec while held", tec, 127);
    set_mode(1'b0);

    // R8: recovery sequence
    mark();
    pulse_op(OP_REC11, 31);
    chk("R8", "tec after 31", tec, 96);
    chk("R8", "err still set", err_status, 1);
    pulse_op(OP_REC11, 1);
    chk("R8", "err clear under limit", err_status, 0);
    chk("R8", "bus still set", bus_status, 1);
    chk("R8", "warn pulse under limit", wtot - w0, 1);
    pulse_op(OP_REC11, 95);
    chk("R8", "tec at zero", tec, 0);
    chk("R8", "bus before last", bus_status, 1);
    pulse_op(OP_TXERR, 1);
    chk("R12", "tec during bus-off", tec, 0);
    mark();
    pulse_op(OP_REC11, 1);
    chk("R8", "bus cleared", bus_status, 0);
    chk("R8", "warn pulse on completion", wtot - w0, 1);
    chk("R8", "rec after completion", rec, 0);

    // R13: enables gate interrupts
    irq_en = 2'b00;
    set_mode(1'b1);
    write_reg(2'd1, 8'd200);
    mark();
    set_mode(1'b0);
    chk("R13", "err_status set", err_status, 1);
    chk("R13", "err_passive set", err_passive, 1);
    chk("R13", "gated warn", wtot - w0, 0);
    chk("R13", "gated passive", ptot - p0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule